// File: doc/BRIEF.md
# Key-Locked Reset Watchdog

This block is a reset watchdog for a power-management die. A slow timebase, delivered as a one-cycle `tick` strobe at 32768 Hz, drives a 32-bit down-counter. Software reaches the block through a small 16-bit register port. The load and control registers are guarded by a lock. A single magic value written to the lock offset opens them, and any other value written there closes them again.

To arm the watchdog, software opens the lock and writes the two halves of the timeout. It then sets the run bit together with the reset-enable bit. When the count runs out, the block holds `sys_rst_o` high for a fixed number of ticks. Two enable inputs control operation. `if_en` gates the register interface and counting. `wclk_en` gates counting only. The watchdog counts only while both are high.

Top module: `keylock_wdt`

## Requirements
- R1: After reset the lock is closed (lock offset reads 1), both load halves and the control register read 0, and `sys_rst_o` is low.
- R2: A write of 16'hE551 to offset 0xA0 opens the lock, which then reads 0. A write of any other value to 0xA0 closes it, which then reads 1.
- R3: While the lock is closed, writes to offsets 0x80, 0x84 and 0x88 leave those registers unchanged, as seen by reading them back.
- R4: Offset 0x80 holds the low 16 bits of the timeout and 0x84 the high 16 bits. Offset 0x88 is control: bit 1 run, bit 2 reload-on-write, bit 3 reset enable. All other control bits read 0, and unmapped offsets read 0.
- R5: When run goes from 0 to 1, the counter loads {high, low}. Each tick while running decrements it. Expiry happens on the L-th tick for a load L of 1 or more, and on the first tick for L = 0. After expiry the counter reloads and keeps going.
- R6: On an expiry with reset enable set, `sys_rst_o` rises at the clock edge carrying the expiring tick and stays high for exactly 4 ticks.
- R7: With reset enable clear, expiry never raises `sys_rst_o`.
- R8: While `if_en` is low, register writes are ignored, reads return 0 and the counter does not advance.
- R9: While `wclk_en` is low, ticks do not advance the counter. Counting resumes from the held value once it returns high.
- R10: With reload-on-write and run both set, an accepted write to 0x80 restarts the counter at once from {high, new low}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle strobe at the 32768 Hz timebase |
| if_en | input | 1 | Interface enable; also required for counting |
| wclk_en | input | 1 | Work-clock enable; required for counting |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| sys_rst_o | output | 1 | System reset pulse |

## Verification
The timeout path is driven with a table of loads: 1, 3, 6, zero, and one case with reset enable clear. These separate the true decrement count from an off-by-one. They also separate the zero-load corner from a counter that wraps, and a reset-gated expiry from a free-running one. A load with only the high half set shows that both halves reach the counter in the right place. Directed runs pause the count with each enable in turn and restart the count mid-flight through the reload-on-write bit. Together they tell a held count apart from a restarted one. The lock is exercised with the key, a wrong key and a relock. Writes made while locked are read back unchanged.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int REG_AW = 8;
    localparam int REG_DW = 16;
    localparam int CNT_W  = 2 * REG_DW;

    localparam logic [REG_AW-1:0] OFS_LOAD_LO = 8'h80;
    localparam logic [REG_AW-1:0] OFS_LOAD_HI = 8'h84;
    localparam logic [REG_AW-1:0] OFS_CTRL    = 8'h88;
    localparam logic [REG_AW-1:0] OFS_LOCK    = 8'hA0;

    localparam logic [REG_DW-1:0] UNLOCK_KEY = 16'hE551;

    localparam int BIT_RUN    = 1;
    localparam int BIT_RELOAD = 2;
    localparam int BIT_RSTEN  = 3;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_LO,
        SEL_HI,
        SEL_CTRL,
        SEL_LOCK
    } reg_sel_e;

    typedef struct packed {
        logic rst_en;
        logic reload_on_wr;
        logic run;
    } ctrl_t;

    function automatic reg_sel_e decode_ofs(input logic [REG_AW-1:0] a);
        case (a)
            OFS_LOAD_LO: decode_ofs = SEL_LO;
            OFS_LOAD_HI: decode_ofs = SEL_HI;
            OFS_CTRL:    decode_ofs = SEL_CTRL;
            OFS_LOCK:    decode_ofs = SEL_LOCK;
            default:     decode_ofs = SEL_NONE;
        endcase
    endfunction

    function automatic ctrl_t ctrl_from_word(input logic [REG_DW-1:0] w);
        ctrl_t c;
        c.run          = w[BIT_RUN];
        c.reload_on_wr = w[BIT_RELOAD];
        c.rst_en       = w[BIT_RSTEN];
        return c;
    endfunction

    function automatic logic [REG_DW-1:0] ctrl_to_word(input ctrl_t c);
        logic [REG_DW-1:0] w;
        w             = '0;
        w[BIT_RUN]    = c.run;
        w[BIT_RELOAD] = c.reload_on_wr;
        w[BIT_RSTEN]  = c.rst_en;
        return w;
    endfunction

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              if_en,
    input  logic              wr,
    input  logic [REG_AW-1:0] addr,
    input  logic [REG_DW-1:0] wdata,
    output logic [REG_DW-1:0] rdata,
    output logic [CNT_W-1:0]  load_val,
    output logic [CNT_W-1:0]  load_next_lo,
    output ctrl_t             ctrl_q,
    output logic              locked_q,
    output logic              run_start,
    output logic              lo_write
);

    logic [REG_DW-1:0] lo_q;
    logic [REG_DW-1:0] hi_q;
    reg_sel_e          sel;
    logic              accept;
    logic              open_wr;
    ctrl_t             ctrl_new;

    assign sel      = decode_ofs(addr);
    assign accept   = wr && if_en;
    assign open_wr  = accept && !locked_q;
    assign ctrl_new = ctrl_from_word(wdata);

    assign run_start    = open_wr && (sel == SEL_CTRL) && ctrl_new.run && !ctrl_q.run;
    assign lo_write     = open_wr && (sel == SEL_LO);
    assign load_val     = {hi_q, lo_q};
    assign load_next_lo = {hi_q, wdata};

    always_ff @(posedge clk) begin
        if (rst) begin
            locked_q <= 1'b1;
            lo_q     <= '0;
            hi_q     <= '0;
            ctrl_q   <= '0;
        end else if (accept) begin
            case (sel)
                SEL_LOCK: locked_q <= (wdata != UNLOCK_KEY);
                SEL_LO:   if (!locked_q) lo_q <= wdata;
                SEL_HI:   if (!locked_q) hi_q <= wdata;
                SEL_CTRL: if (!locked_q) ctrl_q <= ctrl_new;
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        if (if_en) begin
            case (sel)
                SEL_LO:   rdata = lo_q;
                SEL_HI:   rdata = hi_q;
                SEL_CTRL: rdata = ctrl_to_word(ctrl_q);
                SEL_LOCK: rdata = {{(REG_DW-1){1'b0}}, locked_q};
                default:  rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          cnt_en,
    input  logic          run,
    input  logic          run_start,
    input  logic          reload_req,
    input  logic [CW-1:0] load_val,
    input  logic [CW-1:0] reload_val,
    output logic [CW-1:0] count_q,
    output logic          expire
);

    logic step;

    assign step   = run && cnt_en && tick;
    assign expire = step && (count_q <= CW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (run_start) begin
            count_q <= load_val;
        end else if (reload_req) begin
            count_q <= reload_val;
        end else if (expire) begin
            count_q <= load_val;
        end else if (step) begin
            count_q <= count_q - CW'(1);
        end
    end

endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
    parameter int PULSE_TICKS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic fire,
    output logic active
);

    localparam int PW = $clog2(PULSE_TICKS + 1);

    logic [PW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
        end else if (fire) begin
            left_q <= PW'(PULSE_TICKS);
        end else if (tick && (left_q != '0)) begin
            left_q <= left_q - PW'(1);
        end
    end

    assign active = (left_q != '0);

endmodule

// File: rtl/keylock_wdt.sv
module keylock_wdt
    import wdt_pkg::*;
#(
    parameter int PULSE_TICKS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              if_en,
    input  logic              wclk_en,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    output logic              sys_rst_o
);

    logic [CNT_W-1:0] load_val;
    logic [CNT_W-1:0] load_next_lo;
    ctrl_t            ctrl_q;
    logic             locked_q;
    logic             run_start;
    logic             lo_write;
    logic [CNT_W-1:0] count_q;
    logic             expire;
    logic             reload_req;

    wdt_regs u_regs (
        .clk          (clk),
        .rst          (rst),
        .if_en        (if_en),
        .wr           (reg_wr),
        .addr         (reg_addr),
        .wdata        (reg_wdata),
        .rdata        (reg_rdata),
        .load_val     (load_val),
        .load_next_lo (load_next_lo),
        .ctrl_q       (ctrl_q),
        .locked_q     (locked_q),
        .run_start    (run_start),
        .lo_write     (lo_write)
    );

    assign reload_req = lo_write && ctrl_q.run && ctrl_q.reload_on_wr;

    wdt_count #(.CW(CNT_W)) u_count (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .cnt_en     (if_en && wclk_en),
        .run        (ctrl_q.run),
        .run_start  (run_start),
        .reload_req (reload_req),
        .load_val   (load_val),
        .reload_val (load_next_lo),
        .count_q    (count_q),
        .expire     (expire)
    );

    wdt_pulse #(.PULSE_TICKS(PULSE_TICKS)) u_pulse (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .fire   (expire && ctrl_q.rst_en),
        .active (sys_rst_o)
    );

endmodule

// File: rtl/keylock_wdt_chk.sv
module keylock_wdt_chk
    import wdt_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic              if_en,
    input logic              wclk_en,
    input logic              reg_wr,
    input logic [REG_AW-1:0] reg_addr,
    input logic [REG_DW-1:0] reg_wdata,
    input logic              sys_rst_o,
    input logic              locked_q,
    input ctrl_t             ctrl_q,
    input logic [CNT_W-1:0]  load_val,
    input logic [CNT_W-1:0]  count_q,
    input logic              expire
);

    p_unlock_r2: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && if_en && reg_addr == OFS_LOCK && reg_wdata == UNLOCK_KEY) |=> !locked_q);

    p_relock_r2: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && if_en && reg_addr == OFS_LOCK && reg_wdata != UNLOCK_KEY) |=> locked_q);

    p_locked_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (locked_q && reg_addr != OFS_LOCK) |=> ($stable(load_val) && $stable(ctrl_q)));

    p_tick_dec_r5: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.run && if_en && wclk_en && tick && count_q > 32'd1 && !reg_wr)
        |=> (count_q == $past(count_q) - 32'd1));

    p_rise_on_expiry_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(sys_rst_o) |-> $past(expire));

    p_no_rst_disabled_r7: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.rst_en && !sys_rst_o) |=> !sys_rst_o);

    p_if_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !if_en |=> ($stable(count_q) && $stable(load_val) && $stable(locked_q)));

    p_wclk_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!wclk_en && !reg_wr) |=> $stable(count_q));

endmodule

bind keylock_wdt keylock_wdt_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .if_en     (if_en),
    .wclk_en   (wclk_en),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .sys_rst_o (sys_rst_o),
    .locked_q  (locked_q),
    .ctrl_q    (ctrl_q),
    .load_val  (load_val),
    .count_q   (count_q),
    .expire    (expire)
);

// File: tb/test_keylock_wdt.sv
module test_keylock_wdt;

    localparam int CLK_PERIOD = 10;
    localparam int N_VEC = 5;
    // {load_lo[64:49], load_hi[48:33], rst_en[32], expected ticks[31:0]}
    localparam logic [64:0] VEC [N_VEC] = '{
        {16'd1, 16'd0, 1'b1, 32'd1},
        {16'd3, 16'd0, 1'b1, 32'd3},
        {16'd0, 16'd0, 1'b1, 32'd1},
        {16'd6, 16'd0, 1'b1, 32'd6},
        {16'd2, 16'd0, 1'b0, 32'd0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        if_en = 1'b1;
    logic        wclk_en = 1'b1;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        sys_rst_o;

    int checks = 0;
    int fails = 0;

    keylock_wdt i_keylock_wdt (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .if_en     (if_en),
        .wclk_en   (wclk_en),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .sys_rst_o (sys_rst_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [15:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic one_tick();
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    // stop the counter and let any running pulse finish
    task automatic stop_and_drain(input string req);
        wr_reg(8'h88, 16'h0000);
        repeat (4) one_tick();
        check(sys_rst_o == 1'b0, req, sys_rst_o, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] rv;
        int got;
        int width;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd_reg(8'hA0, rv); check(rv == 16'd1, "R1 lock", rv, 1);
        rd_reg(8'h80, rv); check(rv == 16'd0, "R1 load_lo", rv, 0);
        rd_reg(8'h84, rv); check(rv == 16'd0, "R1 load_hi", rv, 0);
        rd_reg(8'h88, rv); check(rv == 16'd0, "R1 ctrl", rv, 0);
        check(sys_rst_o == 1'b0, "R1 sys_rst", sys_rst_o, 0);

        // R3 writes ignored while locked
        wr_reg(8'h80, 16'h1234);
        rd_reg(8'h80, rv); check(rv == 16'd0, "R3 lo locked", rv, 0);
        wr_reg(8'h88, 16'h000A);
        rd_reg(8'h88, rv); check(rv == 16'd0, "R3 ctrl locked", rv, 0);

        // R2 wrong key, right key
        wr_reg(8'hA0, 16'h1111);
        rd_reg(8'hA0, rv); check(rv == 16'd1, "R2 wrong key", rv, 1);
        wr_reg(8'hA0, 16'hE551);
        rd_reg(8'hA0, rv); check(rv == 16'd0, "R2 unlock", rv, 0);

        // R4 layout
        wr_reg(8'h88, 16'hFFF1);
        rd_reg(8'h88, rv); check(rv == 16'h0000, "R4 ctrl mask a", rv, 0);
        wr_reg(8'h88, 16'h0004);
        rd_reg(8'h88, rv); check(rv == 16'h0004, "R4 ctrl bit2", rv, 4);
        wr_reg(8'h88, 16'h0000);
        rd_reg(8'h90, rv); check(rv == 16'h0000, "R4 unmapped", rv, 0);
        wr_reg(8'h84, 16'hBEEF);
        rd_reg(8'h84, rv); check(rv == 16'hBEEF, "R4 hi", rv, 16'hBEEF);
        wr_reg(8'h84, 16'h0000);

        // R5 R6 R7 vector table
        for (int i = 0; i < N_VEC; i++) begin
            logic [15:0] lo;
            logic [15:0] hi;
            logic        en;
            int          exp_t;
            int          lim;
            lo = VEC[i][64:49]; hi = VEC[i][48:33];
            en = VEC[i][32];    exp_t = int'(VEC[i][31:0]);
            wr_reg(8'h80, lo);
            wr_reg(8'h84, hi);
            wr_reg(8'h88, en ? 16'h000A : 16'h0002);
            lim = en ? exp_t + 3 : 8;
            got = 0;
            for (int t = 1; t <= lim && got == 0; t++) begin
                one_tick();
                if (sys_rst_o) got = t;
            end
            if (en) begin
                check(got == exp_t, "R5 expiry tick", got, exp_t);
                wr_reg(8'h88, 16'h0000);
                width = 0;
                for (int t = 1; t <= 8 && width == 0; t++) begin
                    one_tick();
                    if (!sys_rst_o) width = t;
                end
                check(width == 4, "R6 pulse ticks", width, 4);
            end else begin
                check(got == 0, "R7 no reset", got, 0);
                wr_reg(8'h88, 16'h0000);
            end
        end

        // R5 high half of timeout
        wr_reg(8'h80, 16'h0000);
        wr_reg(8'h84, 16'h0001);
        wr_reg(8'h88, 16'h000A);
        repeat (65535) one_tick();
        check(sys_rst_o == 1'b0, "R5 hi before", sys_rst_o, 0);
        one_tick();
        check(sys_rst_o == 1'b1, "R5 hi expiry", sys_rst_o, 1);
        stop_and_drain("R6 drain hi");
        wr_reg(8'h84, 16'h0000);

        // R8 interface enable
        wr_reg(8'h80, 16'h0002);
        wr_reg(8'h88, 16'h000A);
        if_en = 1'b0;
        wr_reg(8'h80, 16'h0055);
        rd_reg(8'h80, rv); check(rv == 16'h0000, "R8 read zero", rv, 0);
        repeat (4) one_tick();
        check(sys_rst_o == 1'b0, "R8 no count", sys_rst_o, 0);
        if_en = 1'b1;
        rd_reg(8'h80, rv); check(rv == 16'h0002, "R8 write ignored", rv, 2);
        one_tick();
        check(sys_rst_o == 1'b0, "R8 resume 1", sys_rst_o, 0);
        one_tick();
        check(sys_rst_o == 1'b1, "R8 resume 2", sys_rst_o, 1);
        stop_and_drain("R8 drain");

        // R9 work clock enable
        wr_reg(8'h80, 16'h0003);
        wr_reg(8'h88, 16'h000A);
        one_tick();
        wclk_en = 1'b0;
        repeat (5) one_tick();
        check(sys_rst_o == 1'b0, "R9 held", sys_rst_o, 0);
        wclk_en = 1'b1;
        one_tick();
        check(sys_rst_o == 1'b0, "R9 resume 1", sys_rst_o, 0);
        one_tick();
        check(sys_rst_o == 1'b1, "R9 resume 2", sys_rst_o, 1);
        stop_and_drain("R9 drain");

        // R10 reload on load-low write
        wr_reg(8'h80, 16'd10);
        wr_reg(8'h88, 16'h000E);
        repeat (3) one_tick();
        wr_reg(8'h80, 16'd2);
        one_tick();
        check(sys_rst_o == 1'b0, "R10 reload 1", sys_rst_o, 0);
        one_tick();
        check(sys_rst_o == 1'b1, "R10 reload 2", sys_rst_o, 1);
        stop_and_drain("R10 drain");

        // R2 relock, R3 ignored after relock
        wr_reg(8'hA0, 16'h0000);
        rd_reg(8'hA0, rv); check(rv == 16'd1, "R2 relock", rv, 1);
        wr_reg(8'h80, 16'h7777);
        rd_reg(8'h80, rv); check(rv == 16'd2, "R3 relocked lo", rv, 2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule